// File: doc/BRIEF.md
# Condition Flag Set Unit

This block turns the processor status flags into data. Each issued operation carries a 4-bit condition code, the current five status flags and the present value of a destination register. The unit decides whether the condition holds and produces the new destination value one clock later.

Two forms of the operation are supported. The plain set form writes a boolean to the destination: the value 1 when the condition holds, otherwise 0. The shift-accumulate form moves the old destination one place to the left and puts the condition outcome into bit 0. Issuing it repeatedly packs a run of condition outcomes into one word, with the most recent outcome in the lowest bit. Neither form touches the status flags. The flags are only read.

The result is held in an output register. It changes only when an operation is issued, so a consumer may sample it at any time after the valid pulse.

Top module: `cfs_unit`

## Requirements
- R1: While reset is asserted (`rst_n` low), and on the first cycle after it is released, `res_valid_o` is 0 and `res_o` is all zeros.
- R2: Set form (`shift_form_i` = 0): one clock after issue, `res_o` equals 32'h0000_0001 if the condition holds and 32'h0000_0000 if it does not.
- R3: Shift-accumulate form (`shift_form_i` = 1): one clock after issue, `res_o` equals `dest_i` shifted left by one place with the condition outcome in bit 0. Bits 31..1 of the result are `dest_i[30:0]`.
- R4: In the shift-accumulate form, bit 31 of `dest_i` is dropped. A set bit 31 has no effect on any bit of the result.
- R5: The flag vector is `flags_i` = {SAT, CY, OV, S, Z}, with Z in bit 0. Codes 0 to 7 test these conditions: 0 OV; 1 CY; 2 Z; 3 CY or Z; 4 S; 5 always; 6 S xor OV; 7 (S xor OV) or Z.
- R6: Each code 8 to 15, apart from 13, tests the inverse of the code that has bit 3 cleared. For example, code 10 holds exactly when Z is 0.
- R7: Code 5 always holds, whatever the flag values. Code 13 holds exactly when the SAT flag is 1.
- R8: `res_valid_o` is 1 in the cycle after a cycle in which `issue_i` was 1, and 0 otherwise. Each operation therefore completes in one clock.
- R9: A cycle without `issue_i` leaves `res_o` unchanged, whatever the other inputs carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_i | input | 1 | Operation issued this cycle |
| shift_form_i | input | 1 | 0 = set form, 1 = shift-accumulate form |
| cond_i | input | 4 | Condition code |
| flags_i | input | 5 | Status flags {SAT, CY, OV, S, Z} |
| dest_i | input | 32 | Current value of the destination register |
| res_valid_o | output | 1 | Result register was updated in the previous cycle |
| res_o | output | 32 | New destination value |

## Verification
In the shift-accumulate form, two things happen in the same cycle: a set bit 31 of the old value is dropped, and a true condition is inserted at bit 0. The bench provokes this by issuing shift operations with `dest_i[31]` forced to 1 across every condition code and flag pattern. Each result is judged against a behavioural model that rebuilds the word from the old value and its own condition table. A second coincidence is an idle cycle placed directly after an issue while the inputs keep changing. The bench interleaves such gaps and checks in every cycle that the held result stays as it was and that the valid flag drops.

// File: rtl/cfs_pkg.sv
package cfs_pkg;

  localparam int CODE_W   = 4;
  localparam int NUM_CODE = 1 << CODE_W;
  localparam int FLAG_W   = 5;

  // Codes that do not follow the "bit 3 inverts" rule.
  localparam logic [CODE_W-1:0] CODE_ALWAYS = 4'd5;
  localparam logic [CODE_W-1:0] CODE_SAT    = 4'd13;

  typedef struct packed {
    logic sat;
    logic cy;
    logic ov;
    logic s;
    logic z;
  } stat_flags_t;

  // Base predicate for the low three bits of the code.
  function automatic logic base_pred(input logic [2:0] sel, input stat_flags_t f);
    logic lt;
    lt = f.s ^ f.ov;
    case (sel)
      3'd0:    base_pred = f.ov;
      3'd1:    base_pred = f.cy;
      3'd2:    base_pred = f.z;
      3'd3:    base_pred = f.cy | f.z;
      3'd4:    base_pred = f.s;
      3'd5:    base_pred = 1'b1;
      3'd6:    base_pred = lt;
      default: base_pred = lt | f.z;
    endcase
  endfunction

  // Full 16-way predicate for one code.
  function automatic logic code_pred(input logic [CODE_W-1:0] code, input stat_flags_t f);
    if (code == CODE_SAT)
      code_pred = f.sat;
    else
      code_pred = base_pred(code[2:0], f) ^ code[CODE_W-1];
  endfunction

endpackage

// File: rtl/cfs_cond_eval.sv
module cfs_cond_eval
  import cfs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] code_i,
  input  logic [FLAG_W-1:0] flags_i,
  output logic              hit_o
);

  stat_flags_t          fl;
  logic [NUM_CODE-1:0]  hit_vec;

  assign fl = stat_flags_t'(flags_i);

  // One predicate per code; the code then picks one of them.
  for (genvar gi = 0; gi < NUM_CODE; gi++) begin : g_code
    assign hit_vec[gi] = code_pred(CODE_W'(gi), fl);
  end

  assign hit_o = hit_vec[code_i];

  // R6: complementary codes never agree
  p_complement_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (code_i[2:0] != 3'd5) |-> (hit_vec[code_i] != hit_vec[code_i ^ 4'd8]));

  // R7: code 5 always holds
  p_always_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (code_i == CODE_ALWAYS) |-> hit_o);

endmodule

// File: rtl/cfs_result_mux.sv
module cfs_result_mux #(
  parameter int DATA_W = 32
) (
  input  logic              shift_form_i,
  input  logic              hit_i,
  input  logic [DATA_W-1:0] dest_i,
  output logic [DATA_W-1:0] next_o
);

  logic [DATA_W-1:0] upper;

  // In the set form the upper bits are cleared; in the shift form they
  // take the old value moved up one place.
  always_comb begin
    if (shift_form_i)
      upper = {dest_i[DATA_W-2:0], 1'b0};
    else
      upper = '0;
    next_o = upper | DATA_W'(hit_i);
  end

endmodule

// File: rtl/cfs_unit.sv
module cfs_unit
  import cfs_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_i,
  input  logic              shift_form_i,
  input  logic [3:0]        cond_i,
  input  logic [4:0]        flags_i,
  input  logic [DATA_W-1:0] dest_i,
  output logic              res_valid_o,
  output logic [DATA_W-1:0] res_o
);

  logic              cond_hit;
  logic [DATA_W-1:0] next_val;

  cfs_cond_eval u_eval (
    .clk     (clk),
    .rst_n   (rst_n),
    .code_i  (cond_i),
    .flags_i (flags_i),
    .hit_o   (cond_hit)
  );

  cfs_result_mux #(.DATA_W(DATA_W)) u_mux (
    .shift_form_i (shift_form_i),
    .hit_i        (cond_hit),
    .dest_i       (dest_i),
    .next_o       (next_val)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid_o <= 1'b0;
      res_o       <= '0;
    end else begin
      res_valid_o <= issue_i;
      if (issue_i) res_o <= next_val;
    end
  end

  // R8: valid follows issue by exactly one clock
  p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
    issue_i |=> res_valid_o);
  p_no_spurious_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_i |=> !res_valid_o);

  // R9: idle cycles hold the result
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_i |=> $stable(res_o));

  // R2: set form yields only 0 or 1
  p_set_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && !shift_form_i) |=> (res_o[DATA_W-1:1] == '0));

  // R3: shift form carries the old low bits up one place
  p_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && shift_form_i) |=> (res_o[DATA_W-1:1] == $past(dest_i[DATA_W-2:0])));

  // R2/R3: bit 0 of the result is the condition outcome
  p_bit0_r2: assert property (@(posedge clk) disable iff (!rst_n)
    issue_i |=> (res_o[0] == $past(cond_hit)));

endmodule

// File: tb/test_cfs_unit.sv
module test_cfs_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue_i = 1'b0;
  logic        shift_form_i = 1'b0;
  logic [3:0]  cond_i = '0;
  logic [4:0]  flags_i = '0;
  logic [31:0] dest_i = '0;
  logic        res_valid_o;
  logic [31:0] res_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [31:0] exp_res = '0;
  logic        exp_v = 1'b0;
  string       exp_tag = "R1";

  always #4 clk = ~clk;  // 125 MHz

  cfs_unit i_cfs_unit (
    .clk (clk), .rst_n (rst_n), .issue_i (issue_i), .shift_form_i (shift_form_i),
    .cond_i (cond_i), .flags_i (flags_i), .dest_i (dest_i),
    .res_valid_o (res_valid_o), .res_o (res_o)
  );

  // Behavioural condition table, written from the requirements.
  function automatic bit ref_cond(int code, logic [4:0] f);
    bit z, s, ov, cy, sat, r;
    z = f[0]; s = f[1]; ov = f[2]; cy = f[3]; sat = f[4];
    if (code == 5)  return 1'b1;        // R7
    if (code == 13) return sat;         // R7
    case (code % 8)                     // R5
      0: r = ov;
      1: r = cy;
      2: r = z;
      3: r = cy || z;
      4: r = s;
      6: r = (s != ov);
      default: r = (s != ov) || z;
    endcase
    return (code >= 8) ? !r : r;        // R6
  endfunction

  task automatic check_now();
    checks++;
    if (res_valid_o !== exp_v) begin
      failures++;
      $display("FAIL R8 valid actual=%0b expected=%0b", res_valid_o, exp_v);
    end
    checks++;
    if (res_o !== exp_res) begin
      failures++;
      $display("FAIL %s result actual=%08h expected=%08h", exp_tag, res_o, exp_res);
    end
  endtask

  // Check last cycle's outcome, then drive the next cycle and update the model.
  task automatic step(bit iss, bit sh, int code, logic [4:0] f, logic [31:0] d);
    bit c;
    @(negedge clk);
    check_now();
    issue_i = iss; shift_form_i = sh; cond_i = code[3:0]; flags_i = f; dest_i = d;
    exp_v = iss;
    if (iss) begin
      c = ref_cond(code, f);
      if (sh) exp_res = (d << 1) | 32'(c);
      else    exp_res = c ? 32'd1 : 32'd0;
      if (sh && d[31])                 exp_tag = "R4";
      else if (code == 5 || code == 13) exp_tag = "R7";
      else if (code >= 8)               exp_tag = "R6";
      else if (sh)                      exp_tag = "R3";
      else                              exp_tag = "R5/R2";
    end else begin
      exp_tag = "R9";
    end
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    exp_tag = "R1"; check_now();
    @(negedge clk); rst_n = 1'b1;
    exp_tag = "R1";

    // R2, R5, R6, R7: every code and flag pattern in the set form
    for (int code = 0; code < 16; code++)
      for (int f = 0; f < 32; f++)
        step(1'b1, 1'b0, code, 5'(f), $urandom());

    // R3, R4: shift form with bit 31 forced on, then off
    for (int code = 0; code < 16; code++)
      for (int f = 0; f < 32; f++)
        step(1'b1, 1'b1, code, 5'(f), $urandom() | 32'h8000_0000);
    for (int code = 0; code < 16; code++)
      for (int f = 0; f < 32; f += 3)
        step(1'b1, 1'b1, code, 5'(f), $urandom() & 32'h7FFF_FFFF);

    // R3: accumulate a run of outcomes, feeding the result back
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      step(1'b1, 1'b1, k % 16, 5'($urandom()), res_o);
    end

    // R9, R8: idle gaps with changing inputs, mixed with issues
    for (int k = 0; k < 200; k++)
      step(($urandom() % 3) == 0, $urandom() % 2, $urandom() % 16,
           5'($urandom()), $urandom());

    step(1'b0, 1'b0, 0, 5'd0, 32'd0);
    @(negedge clk); check_now();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule